// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit supervision timer. It advances on count enables from one of two clock domains' tick strobes and has two uses. In watchdog mode it must be cleared by software before the selected interval runs out, or it asks the system for a reset. In interval mode it acts as a periodic timer that sets a flag and can raise an interrupt. Software changes the configuration only through a control word whose upper byte must carry a fixed key. A write with any other key is dropped and is itself treated as a fault that requests a reset.

A second, unkeyed word holds the two sticky event flags and the two interrupt enables. The expiry flag keeps its value through the reset that the block requests, so start-up code can find out why the system restarted. The block also decides what the external reset pin does. It either passes a low level on as a reset request, or turns a falling edge into a non-maskable interrupt event.

Each reset request lasts one cycle. The cycle after it, the block applies its own soft reset: the configuration returns to its defaults, the count returns to zero and both interrupt enables are cleared, while the flags are kept.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset the control word reads 0x6900 (running, watchdog mode, interval code 00, source A, pin in reset function), the flag word reads 0x0000, and rst_req, tmr_irq and nmi_req are low.
- R2: A write to address 0 changes the configuration only when wr_data[15:8] is 0x5A. Any other upper byte leaves the configuration unchanged, and rst_req is high in the cycle after that write.
- R3: While control bit 7 (hold) is 1, the count does not advance and no expiry occurs. While it is 0, the count advances on every cycle in which the selected tick is high.
- R4: Control bit 2 selects the count enable: 0 takes tick_a and 1 takes tick_b. Ticks on the other input have no effect.
- R5: A keyed write with control bit 3 set makes the count zero, and that bit always reads back as 0. A keyed write with bit 3 clear leaves the count running from its current value.
- R6: Control bits 1:0 select counter bit 15, 13, 9 or 6 for codes 00, 01, 10 and 11. Expiry occurs on the tick at which the selected bit rises, that is, 32768, 8192, 512 or 64 ticks after a clear. Counting then continues, so later expiries follow every 65536, 16384, 1024 or 128 ticks.
- R7: In watchdog mode (control bit 4 = 0), expiry sets the expiry flag and makes rst_req high for one cycle, starting in the cycle after the expiring tick.
- R8: In interval mode (control bit 4 = 1), expiry sets the expiry flag and does not request a reset. tmr_irq equals expiry flag AND timer interrupt enable (flag word bit 5) while in interval mode.
- R9: The flag word at address 1 holds the expiry flag in bit 0 and the NMI flag in bit 1. A write to address 1 stores both bits, and a hardware set in the same cycle wins. Nothing else clears a flag except power-on reset.
- R10: In the cycle after rst_req is high, the control word returns to 0x6900, the count returns to zero, and the NMI enable (bit 4) and timer interrupt enable (bit 5) of the flag word return to 0. Both flags keep their values.
- R11: With control bit 5 = 0, a low level on pin_rst_n makes rst_req high in the next cycle. With bit 5 = 1, a falling edge on pin_rst_n sets the NMI flag and requests no reset. Holding the pin low does not set the flag again.
- R12: nmi_req equals NMI flag AND NMI enable (flag word bit 4).
- R13: Reading address 0 returns 0x69 in bits 15:8 and 0 in bits 6 and 3. Reading address 1 returns 0 in bits 15:6, 3 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously and released synchronously inside |
| tick_a | input | 1 | Count enable from the first clock source |
| tick_b | input | 1 | Count enable from the second clock source |
| pin_rst_n | input | 1 | External reset pin level, active low, already synchronous to clk |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | Word select: 0 control word, 1 flag word (reads and writes) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected word |
| rst_req | output | 1 | System reset request |
| tmr_irq | output | 1 | Interval-timer interrupt request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The timeout is checked at all four interval codes. Each check measures the exact tick on which the flag rises, which separates a correct tap from an off-by-one count or a swapped code. A free-running interval run measures the second expiry, which confirms that the count continues after expiry instead of restarting. Petting sequences compare keyed writes with and without the clear bit, and tick patterns with only one source active show which enable the counter follows. Keyed and unkeyed writes, and a pin held low in each of its two functions, separate a real reset request from a dropped one, and show that the expiry flag survives the soft reset that follows.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int KEY_W  = 8;
  localparam int CFG_W  = DATA_W - KEY_W;

  localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
  localparam logic [KEY_W-1:0] RD_KEY = 8'h69;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  // Control word bit positions (low byte)
  localparam int BIT_HOLD = 7;
  localparam int BIT_PIN  = 5;
  localparam int BIT_MODE = 4;
  localparam int BIT_CLR  = 3;
  localparam int BIT_SRC  = 2;

  // Flag word bit positions
  localparam int BIT_EXPF = 0;
  localparam int BIT_NMIF = 1;
  localparam int BIT_NMIE = 4;
  localparam int BIT_TIE  = 5;

  // Counter tap per interval code
  localparam int N_TAPS = 4;
  localparam int TAP_BIT [N_TAPS] = '{15, 13, 9, 6};

  typedef enum logic {
    MODE_WDOG = 1'b0,
    MODE_INTV = 1'b1
  } mode_e;

  typedef struct packed {
    logic       hold;
    logic       pin_nmi;
    mode_e      mode;
    logic       src_b;
    logic [1:0] ival;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{hold: 1'b0, pin_nmi: 1'b0, mode: MODE_WDOG,
                                 src_b: 1'b0, ival: 2'b00};

  function automatic ctrl_t ctrl_from_byte(input logic [CFG_W-1:0] b);
    ctrl_t c;
    c.hold    = b[BIT_HOLD];
    c.pin_nmi = b[BIT_PIN];
    c.mode    = mode_e'(b[BIT_MODE]);
    c.src_b   = b[BIT_SRC];
    c.ival    = b[1:0];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] ctrl_to_byte(input ctrl_t c);
    logic [CFG_W-1:0] b;
    b           = '0;
    b[BIT_HOLD] = c.hold;
    b[BIT_PIN]  = c.pin_nmi;
    b[BIT_MODE] = c.mode;
    b[BIT_SRC]  = c.src_b;
    b[1:0]      = c.ival;
    return b;
  endfunction

endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              soft_rst,
  output ctrl_t             ctrl_q,
  output logic              cnt_clr,
  output logic              bad_key
);

  logic  sel;
  logic  key_ok;
  ctrl_t ctrl_d;

  always_comb begin
    sel     = wr_en && (addr == ADDR_CTRL);
    key_ok  = (wr_data[DATA_W-1 -: KEY_W] == WR_KEY);
    bad_key = sel && !key_ok;
    cnt_clr = sel && key_ok && wr_data[BIT_CLR];
    ctrl_d  = ctrl_q;
    if (soft_rst) begin
      ctrl_d = CTRL_RST;
    end else if (sel && key_ok) begin
      ctrl_d = ctrl_from_byte(wr_data[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  AST_BADKEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_key && !soft_rst) |=> $stable(ctrl_q)); // R2

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == CTRL_RST)); // R10

endmodule

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_a,
  input  logic  tick_b,
  input  ctrl_t ctrl,
  input  logic  cnt_clr,
  input  logic  soft_rst,
  output logic  expire
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  cnt_inc;
  logic              adv;
  logic [N_TAPS-1:0] tap_rise;

  assign cnt_inc = cnt_q + 1'b1;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign tap_rise[g] = !cnt_q[TAP_BIT[g]] && cnt_inc[TAP_BIT[g]];
  end

  always_comb begin
    adv    = !ctrl.hold && (ctrl.src_b ? tick_b : tick_a);
    expire = adv && !soft_rst && !cnt_clr && tap_rise[ctrl.ival];
    cnt_d  = cnt_q;
    if (soft_rst || cnt_clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.hold && !cnt_clr && !soft_rst) |=> $stable(cnt_q)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/wdg_event.sv
module wdg_event
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              bad_key,
  input  ctrl_t             ctrl,
  input  logic              pin_rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CFG_W-1:0]  flag_byte,
  output logic              rst_req,
  output logic              soft_rst,
  output logic              tmr_irq,
  output logic              nmi_req
);

  logic exp_q, exp_d;
  logic nmif_q, nmif_d;
  logic nmie_q, nmie_d;
  logic tie_q, tie_d;
  logic pin_q;
  logic req_q, req_d;
  logic flag_wr;
  logic pin_fall;
  logic pin_rst_lvl;

  always_comb begin
    flag_wr     = wr_en && (addr == ADDR_FLAG);
    pin_fall    = ctrl.pin_nmi && pin_q && !pin_rst_n;
    pin_rst_lvl = !ctrl.pin_nmi && !pin_rst_n;

    req_d = (expire && (ctrl.mode == MODE_WDOG)) || bad_key || pin_rst_lvl;

    exp_d  = exp_q;
    nmif_d = nmif_q;
    if (flag_wr) begin
      exp_d  = wr_data[BIT_EXPF];
      nmif_d = wr_data[BIT_NMIF];
    end
    if (expire) begin
      exp_d = 1'b1;
    end
    if (pin_fall) begin
      nmif_d = 1'b1;
    end

    nmie_d = nmie_q;
    tie_d  = tie_q;
    if (req_q) begin
      nmie_d = 1'b0;
      tie_d  = 1'b0;
    end else if (flag_wr) begin
      nmie_d = wr_data[BIT_NMIE];
      tie_d  = wr_data[BIT_TIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      nmif_q <= 1'b0;
      nmie_q <= 1'b0;
      tie_q  <= 1'b0;
      pin_q  <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      exp_q  <= exp_d;
      nmif_q <= nmif_d;
      nmie_q <= nmie_d;
      tie_q  <= tie_d;
      pin_q  <= pin_rst_n;
      req_q  <= req_d;
    end
  end

  always_comb begin
    flag_byte           = '0;
    flag_byte[BIT_EXPF] = exp_q;
    flag_byte[BIT_NMIF] = nmif_q;
    flag_byte[BIT_NMIE] = nmie_q;
    flag_byte[BIT_TIE]  = tie_q;
  end

  assign rst_req  = req_q;
  assign soft_rst = req_q;
  assign tmr_irq  = exp_q && tie_q && (ctrl.mode == MODE_INTV);
  assign nmi_req  = nmif_q && nmie_q;

  AST_WDOG_EXPIRE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (ctrl.mode == MODE_WDOG)) |=> rst_req); // R7

  AST_BADKEY_RST: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> rst_req); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !flag_wr) |=> exp_q); // R9

  AST_NMI_MODE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pin_nmi && !expire && !bad_key) |=> !rst_req); // R11

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_a,
  input  logic        tick_b,
  input  logic        pin_rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        rst_req,
  output logic        tmr_irq,
  output logic        nmi_req
);

  logic             rst_meta_q;
  logic             rst_sync_n;
  ctrl_t            ctrl_q;
  logic             cnt_clr;
  logic             bad_key;
  logic             expire;
  logic             soft_rst;
  logic [CFG_W-1:0] flag_byte;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wdg_cfg i_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .soft_rst (soft_rst),
    .ctrl_q   (ctrl_q),
    .cnt_clr  (cnt_clr),
    .bad_key  (bad_key)
  );

  wdg_count i_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_a   (tick_a),
    .tick_b   (tick_b),
    .ctrl     (ctrl_q),
    .cnt_clr  (cnt_clr),
    .soft_rst (soft_rst),
    .expire   (expire)
  );

  wdg_event i_event (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .expire    (expire),
    .bad_key   (bad_key),
    .ctrl      (ctrl_q),
    .pin_rst_n (pin_rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .flag_byte (flag_byte),
    .rst_req   (rst_req),
    .soft_rst  (soft_rst),
    .tmr_irq   (tmr_irq),
    .nmi_req   (nmi_req)
  );

  always_comb begin
    if (addr == ADDR_CTRL) begin
      rd_data = {RD_KEY, ctrl_to_byte(ctrl_q)};
    end else begin
      rd_data = {{KEY_W{1'b0}}, flag_byte};
    end
  end

  AST_RD_KEY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr == ADDR_CTRL) |-> (rd_data[15:8] == RD_KEY && !rd_data[BIT_CLR])); // R13

endmodule

// File: tb/test_wdt_guard.sv
`timescale 1ns/100ps
module test_wdt_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_a, tick_b, pin_rst_n;
  logic        wr_en, addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        rst_req, tmr_irq, nmi_req;

  int checks   = 0;
  int failures = 0;
  int rst_seen = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .pin_rst_n(pin_rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rst_req(rst_req), .tmr_irq(tmr_irq), .nmi_req(nmi_req)
  );

  always @(negedge clk) if (rst_req) rst_seen++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; addr = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
    addr = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 16'h6900);
    rd(1'b1, v); chk("R1 flags", v, 16'h0000);
    chk("R1 outs", {13'd0, rst_req, tmr_irq, nmi_req}, 16'h0000);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr(1'b0, 16'h5A8B);
    rd(1'b0, v); chk("R13 R5 clear bit reads 0", v, 16'h6983);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); chk("R13 flag word fixed bits", v, 16'h0033);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_bad_key();
    logic [15:0] v;
    wr(1'b0, 16'h3300);
    rd(1'b0, v); chk("R2 bad key ignored", v, 16'h6983);
    chk("R2 bad key reset", {15'd0, rst_req}, 16'h0001);
    step(1);
    rd(1'b0, v); chk("R10 defaults after reset", v, 16'h6900);
    chk("R2 reset one cycle", {15'd0, rst_req}, 16'h0000);
    wr(1'b0, 16'h5A80);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    tick_a = 1'b1; rst_seen = 0;
    wr(1'b0, 16'h5A8B);
    step(100);
    rd(1'b1, v); chk("R3 hold no expiry", v, 16'h0000);
    chk("R3 hold no reset", rst_seen[15:0], 16'h0000);
    wr(1'b0, 16'h5A03);
    step(63);
    rd(1'b1, v); chk("R3 run before tick 64", v, 16'h0000);
    step(1);
    rd(1'b1, v); chk("R3 R6 expiry at tick 64", v, 16'h0001);
    step(1);
    wr(1'b0, 16'h5A80);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_wdog_expire();
    logic [15:0] v;
    wr(1'b1, 16'h0030);
    wr(1'b0, 16'h5A0B);
    step(63);
    rd(1'b1, v); chk("R7 no flag before", v, 16'h0030);
    chk("R7 no reset before", {15'd0, rst_req}, 16'h0000);
    step(1);
    rd(1'b1, v); chk("R7 flag set", v[0], 1'b1);
    chk("R7 reset request", {15'd0, rst_req}, 16'h0001);
    step(1);
    chk("R7 reset single cycle", {15'd0, rst_req}, 16'h0000);
    rd(1'b0, v); chk("R10 ctrl defaults", v, 16'h6900);
    rd(1'b1, v); chk("R9 R10 flag kept, enables cleared", v, 16'h0001);
    wr(1'b0, 16'h5A80);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_pet();
    logic [15:0] v;
    rst_seen = 0;
    wr(1'b0, 16'h5A0B);
    for (int k = 0; k < 4; k++) begin
      step(39);
      wr(1'b0, 16'h5A0B);
    end
    step(20);
    rd(1'b1, v); chk("R5 petting prevents expiry", v, 16'h0000);
    chk("R5 petting no reset", rst_seen[15:0], 16'h0000);
    wr(1'b0, 16'h5A03);
    step(42);
    rd(1'b1, v); chk("R5 write without clear keeps count", v, 16'h0000);
    step(1);
    rd(1'b1, v); chk("R5 expiry continues old count", v, 16'h0001);
    chk("R5 reset on expiry", {15'd0, rst_req}, 16'h0001);
    step(1);
    wr(1'b0, 16'h5A80);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_source();
    logic [15:0] v;
    tick_a = 1'b1; tick_b = 1'b0;
    wr(1'b0, 16'h5A1F);
    step(100);
    rd(1'b1, v); chk("R4 tick_a ignored on source B", v, 16'h0000);
    tick_b = 1'b1;
    step(63);
    rd(1'b1, v); chk("R4 source B before tick 64", v, 16'h0000);
    step(1);
    rd(1'b1, v); chk("R4 source B expiry", v, 16'h0001);
    chk("R8 irq gated by enable", {15'd0, tmr_irq}, 16'h0000);
    wr(1'b0, 16'h5A80);
    wr(1'b1, 16'h0000);
    tick_b = 1'b0;
  endtask

  task automatic t_interval(input logic [1:0] code, input int ticks);
    logic [15:0] v;
    rst_seen = 0;
    wr(1'b1, 16'h0020);
    wr(1'b0, 16'h5A18 | {14'd0, code});
    step(ticks - 1);
    rd(1'b1, v); chk("R6 no expiry before interval", v, 16'h0020);
    chk("R8 irq low before", {15'd0, tmr_irq}, 16'h0000);
    step(1);
    rd(1'b1, v); chk("R6 expiry at interval", v, 16'h0021);
    chk("R8 irq raised", {15'd0, tmr_irq}, 16'h0001);
    chk("R8 interval mode no reset", rst_seen[15:0], 16'h0000);
    wr(1'b0, 16'h5A80);
    wr(1'b1, 16'h0020);
    chk("R8 irq drops with flag", {15'd0, tmr_irq}, 16'h0000);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_continue();
    logic [15:0] v;
    wr(1'b1, 16'h0020);
    wr(1'b0, 16'h5A1B);
    step(64);
    rd(1'b1, v); chk("R6 first expiry", v, 16'h0021);
    wr(1'b1, 16'h0020);
    step(126);
    rd(1'b1, v); chk("R6 R9 flag cleared, no early expiry", v, 16'h0020);
    step(1);
    rd(1'b1, v); chk("R6 second expiry 128 ticks later", v, 16'h0021);
    wr(1'b0, 16'h5A80);
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_pin();
    logic [15:0] v;
    rst_seen = 0;
    wr(1'b0, 16'h5AA0);
    wr(1'b1, 16'h0010);
    pin_rst_n = 1'b0;
    step(1);
    rd(1'b1, v); chk("R11 nmi flag on fall", v, 16'h0012);
    chk("R12 nmi_req", {15'd0, nmi_req}, 16'h0001);
    chk("R11 nmi mode no reset", {15'd0, rst_req}, 16'h0000);
    pin_rst_n = 1'b1;
    wr(1'b1, 16'h0000);
    chk("R12 nmi_req drops", {15'd0, nmi_req}, 16'h0000);
    pin_rst_n = 1'b0;
    step(1);
    rd(1'b1, v); chk("R11 flag without enable", v, 16'h0002);
    chk("R12 no req without enable", {15'd0, nmi_req}, 16'h0000);
    wr(1'b1, 16'h0000);
    step(3);
    rd(1'b1, v); chk("R11 held low no second event", v, 16'h0000);
    chk("R11 no reset in nmi mode", rst_seen[15:0], 16'h0000);
    pin_rst_n = 1'b1;
    wr(1'b0, 16'h5A80);
    step(1);
    pin_rst_n = 1'b0;
    step(1);
    chk("R11 pin reset request", {15'd0, rst_req}, 16'h0001);
    rd(1'b1, v); chk("R11 no nmi flag in reset mode", v, 16'h0000);
    pin_rst_n = 1'b1;
    step(2);
    chk("R11 reset ends", {15'd0, rst_req}, 16'h0000);
    wr(1'b0, 16'h5A80);
  endtask

  initial begin
    rst_n = 1'b0; tick_a = 1'b0; tick_b = 1'b0; pin_rst_n = 1'b1;
    wr_en = 1'b0; addr = 1'b0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset_state();
    t_readback();
    t_bad_key();
    t_hold();
    t_wdog_expire();
    t_pet();
    t_source();
    t_interval(2'b11, 64);
    t_interval(2'b10, 512);
    t_interval(2'b01, 8192);
    t_interval(2'b00, 32768);
    t_continue();
    t_pin();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule